// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block drives a packet onto the D+/D- pair at the low-speed bit rate. A request names either a data packet, given as a byte count that includes the leading sync byte, or a one-byte handshake reply (ACK or NAK). The block makes the sync byte itself. It takes the bytes that follow from a ready/valid byte source, one byte per strobe, exactly when the byte is needed on the wire.

Once a request is accepted, the block sets the lines to the idle J state. It then enables its drivers and holds J for one bit time. Next it sends every byte least significant bit first, with NRZI coding and bit stuffing. It closes with the end-of-packet sequence and then releases the drivers with both lines low. The block also holds a pending device address. It copies this address into the active address only when a data packet ends, and never after a handshake, so that a new address takes effect once the status reply that carries it has gone out.

Top module: `ls_usb_tx`

## Requirements
- R1: After reset and between packets, usb_oe, usb_dp, usb_dm and busy are all 0. The dev_addr output resets to 0.
- R2: When start is sampled high, the next clock has J on the lines (usb_dm=1, usb_dp=0) with usb_oe=0. The following BIT_CLKS clocks drive J with usb_oe=1. The first sync symbol appears 1+BIT_CLKS clocks after the accepting edge, which is well inside 7.5 bit times.
- R3: The block generates the sync byte 0x80 and sends it first. Every byte goes out bit 0 first. J is usb_dm=1, usb_dp=0 and K is usb_dp=1, usb_dm=0. The two lines are never high together.
- R4: NRZI: a 0 bit toggles the line state and a 1 bit keeps it. Every symbol, stuffed ones included, lasts exactly BIT_CLKS clocks.
- R5: After six consecutive 1 bits the block inserts a 0 symbol. Every 0, stuffed or not, restarts the run. Runs carry across byte boundaries, and a stuffed bit still follows when the sixth 1 is the last bit of the packet.
- R6: For a data packet, byte_count-1 bytes are taken from the source. Each is taken by a one-clock data_ready pulse, and data_in is sampled on the clock edge that ends that pulse. A count of 0 or 1 sends the sync byte only. If data_valid is low during the pulse, the byte is sent as 0x00.
- R7: After the last symbol, the block drives SE0 (both lines low, drivers on) for 2*BIT_CLKS clocks and then J for BIT_CLKS clocks. It then turns the drivers off with both lines low, and busy falls in the same clock.
- R8: With hs_mode=1, the packet is the sync byte followed by the PID byte 0xD2 (hs_ack=1, ACK) or 0x5A (hs_ack=0, NAK). byte_count is ignored and data_ready never pulses.
- R9: busy is high from the clock after acceptance until release. A start while busy is high is ignored, and the packet in flight goes on unchanged.
- R10: An addr_wr pulse loads addr_in into the pending address. dev_addr takes the pending value on entry to SE0 of a data packet, and it does not change after a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, BIT_CLKS periods per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send a packet |
| hs_mode | input | 1 | 1: handshake reply, 0: data packet |
| hs_ack | input | 1 | Handshake kind: 1 ACK, 0 NAK |
| byte_count | input | CNT_W | Data packet length, sync byte included |
| data_in | input | 8 | Next payload byte |
| data_valid | input | 1 | data_in holds a byte |
| data_ready | output | 1 | One-clock strobe: data_in is taken at this edge |
| addr_wr | input | 1 | Load addr_in into the pending address |
| addr_in | input | ADDR_W | New device address |
| dev_addr | output | ADDR_W | Active device address |
| busy | output | 1 | A packet is in progress |
| usb_oe | output | 1 | Line driver enable |
| usb_dp | output | 1 | D+ output level |
| usb_dm | output | 1 | D- output level |

## Verification
The assertions assume a few things about the inputs. Reset is held for some clocks. start, hs_mode, hs_ack and byte_count stay stable around the edge that accepts a request. addr_wr is a single-clock pulse. The stimulus changes every input only on the falling clock edge, so each value is settled at the sampling edge. The byte source shows the next byte on data_in before the strobe that takes it and moves on only in the clock after the strobe. One packet deliberately holds data_valid low to produce the zero-byte case, and another raises start in the middle of a packet to show that it is ignored.

// File: rtl/ls_usb_tx_pkg.sv
package ls_usb_tx_pkg;

  localparam int BYTE_W    = 8;
  localparam int STUFF_RUN = 6;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h80;
  localparam logic [BYTE_W-1:0] PID_ACK   = 8'hD2;
  localparam logic [BYTE_W-1:0] PID_NAK   = 8'h5A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_LEAD, ST_DATA, ST_SE0, ST_EOPJ
  } tx_state_t;

  // line_j = 1 means the J level; a zero bit flips the level
  function automatic logic nrzi_next(input logic line_j, input logic bit_val);
    return bit_val ? line_j : ~line_j;
  endfunction

  // length of the run of ones after sending bit_val
  function automatic logic [2:0] run_next(input logic [2:0] run, input logic bit_val);
    return bit_val ? run + 3'd1 : 3'd0;
  endfunction

  function automatic logic [BYTE_W-1:0] hs_pid(input logic ack);
    return ack ? PID_ACK : PID_NAK;
  endfunction

endpackage

// File: rtl/ls_usb_tx_bittimer.sv
module ls_usb_tx_bittimer #(
  parameter int BIT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic period_end
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)   cnt <= '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign period_end = (cnt == LAST) && !restart;
endmodule

// File: rtl/ls_usb_tx_encoder.sv
module ls_usb_tx_encoder
  import ls_usb_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic [BYTE_W-1:0] next_byte,
  input  logic              more,
  output logic              line_j,
  output logic              stuff_due,
  output logic              byte_end,
  output logic              done
);
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bidx;
  logic [2:0]        ones;

  assign stuff_due = (ones == 3'(STUFF_RUN));
  assign byte_end  = step && !stuff_due && (bidx == 3'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; bidx <= '0; ones <= '0; line_j <= 1'b1; done <= 1'b0;
    end else if (init) begin
      sh <= SYNC_BYTE; bidx <= '0; ones <= '0; line_j <= 1'b1; done <= 1'b0;
    end else if (step) begin
      if (stuff_due) begin
        line_j <= ~line_j;
        ones   <= '0;
      end else begin
        line_j <= nrzi_next(line_j, sh[0]);
        ones   <= run_next(ones, sh[0]);
        bidx   <= bidx + 3'd1;
        if (byte_end) begin
          if (more) sh <= next_byte;
          else      done <= 1'b1;
        end else begin
          sh <= sh >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import ls_usb_tx_pkg::*;
#(
  parameter int BIT_CLKS = 8,
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_mode,
  input  logic              hs_ack,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [7:0]        data_in,
  input  logic              data_valid,
  output logic              data_ready,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              busy,
  output logic              usb_oe,
  output logic              usb_dp,
  output logic              usb_dm
);
  tx_state_t         state;
  logic              hs_r;
  logic [7:0]        pid_r;
  logic [CNT_W-1:0]  left;
  logic              se0_half;
  logic [ADDR_W-1:0] pend_addr;

  logic period_end, accept, step, eop_go, byte_take, commit;
  logic line_j, stuff_due, byte_end, enc_done;
  logic [7:0] next_byte;

  assign accept    = start && (state == ST_IDLE);
  assign eop_go    = (state == ST_DATA) && period_end && enc_done && !stuff_due;
  assign step      = period_end && ((state == ST_LEAD) ||
                     ((state == ST_DATA) && !(enc_done && !stuff_due)));
  assign byte_take = byte_end && (left != '0);
  assign data_ready = byte_take && !hs_r;
  assign next_byte = hs_r ? pid_r : (data_valid ? data_in : 8'h00);
  assign commit    = eop_go && !hs_r;

  ls_usb_tx_bittimer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .restart((state == ST_IDLE) || (state == ST_PREP)),
    .period_end(period_end)
  );

  ls_usb_tx_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .init(accept), .step(step),
    .next_byte(next_byte), .more(left != '0),
    .line_j(line_j), .stuff_due(stuff_due), .byte_end(byte_end), .done(enc_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; hs_r <= 1'b0; pid_r <= '0; left <= '0; se0_half <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_PREP;
          hs_r  <= hs_mode;
          pid_r <= hs_pid(hs_ack);
          if (hs_mode)                   left <= CNT_W'(1);
          else if (byte_count <= CNT_W'(1)) left <= '0;
          else                           left <= byte_count - CNT_W'(1);
        end
        ST_PREP: state <= ST_LEAD;
        ST_LEAD: if (period_end) state <= ST_DATA;
        ST_DATA: begin
          if (byte_take) left <= left - CNT_W'(1);
          if (eop_go) begin
            state <= ST_SE0; se0_half <= 1'b0;
          end
        end
        ST_SE0: if (period_end) begin
          if (se0_half) state <= ST_EOPJ;
          else          se0_half <= 1'b1;
        end
        ST_EOPJ: if (period_end) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr <= '0; dev_addr <= '0;
    end else begin
      if (addr_wr) pend_addr <= addr_in;
      if (commit)  dev_addr  <= pend_addr;
    end
  end

  always_comb begin
    usb_oe = 1'b0; usb_dp = 1'b0; usb_dm = 1'b0;
    case (state)
      ST_PREP:         usb_dm = 1'b1;
      ST_LEAD, ST_EOPJ: begin usb_oe = 1'b1; usb_dm = 1'b1; end
      ST_DATA: begin usb_oe = 1'b1; usb_dm = line_j; usb_dp = ~line_j; end
      ST_SE0:          usb_oe = 1'b1;
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/ls_usb_tx_chk.sv
module ls_usb_tx_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              usb_oe,
  input logic              usb_dp,
  input logic              usb_dm,
  input logic              data_ready,
  input logic              hs_active,
  input logic              period_end,
  input logic [ADDR_W-1:0] dev_addr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!usb_oe && !usb_dp && !usb_dm));

  a_r3_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(usb_dp && usb_dm));

  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_oe && $past(usb_oe) && !$past(period_end)) |-> $stable({usb_dp, usb_dm}));

  a_r6_ready_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (busy && !hs_active));

  a_r7_release_from_j: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usb_oe) |-> (!busy && $past(usb_dm) && !$past(usb_dp)));

  a_r10_addr_at_eop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> (usb_oe && !usb_dp && !usb_dm && !$past(hs_active)));
endmodule

bind ls_usb_tx ls_usb_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .usb_oe(usb_oe), .usb_dp(usb_dp),
  .usb_dm(usb_dm), .data_ready(data_ready), .hs_active(hs_r),
  .period_end(period_end), .dev_addr(dev_addr)
);

// File: tb/ls_usb_tx_test.sv
module ls_usb_tx_test;
  localparam int BC = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, hs_mode, hs_ack, data_valid, addr_wr;
  logic [7:0] byte_count, data_in;
  logic [6:0] addr_in;
  logic data_ready, busy, usb_oe, usb_dp, usb_dm;
  logic [6:0] dev_addr;

  ls_usb_tx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_ack(hs_ack),
    .byte_count(byte_count), .data_in(data_in), .data_valid(data_valid),
    .data_ready(data_ready), .addr_wr(addr_wr), .addr_in(addr_in),
    .dev_addr(dev_addr), .busy(busy), .usb_oe(usb_oe), .usb_dp(usb_dp), .usb_dm(usb_dm)
  );

  int total = 0, bad = 0;
  logic [7:0] src [0:7];
  int src_idx = 0, takes = 0;
  bit took_prev = 0;
  logic [3:0] exp_q [$];   // {busy, oe, dp, dm}
  string      tag_q [$];

  // byte source: data_in shows src[idx]; advances the clock after a strobe
  always @(negedge clk) begin
    if (took_prev) src_idx++;
    took_prev = data_ready;
    if (data_ready) takes++;
    data_in = src[src_idx[2:0]];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic push_n(input logic [3:0] v, input int n, input string t);
    for (int i = 0; i < n; i++) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  // behavioural model of the wire, built from the requirements
  task automatic build(input bit hs, input bit ack, input int count, input bit valid,
                       input string body_tag);
    bit bits [$];
    bit lvl;
    int run, nb;
    logic [7:0] b;
    exp_q.delete(); tag_q.delete();
    nb = hs ? 1 : (count <= 1 ? 0 : count - 1);
    for (int k = 0; k < 8; k++) bits.push_back(k == 7);          // sync 0x80
    for (int j = 0; j < nb; j++) begin
      b = hs ? (ack ? 8'hD2 : 8'h5A) : (valid ? src[j] : 8'h00);
      for (int k = 0; k < 8; k++) bits.push_back(b[k]);
    end
    push_n(4'b1001, 1, "R2");
    push_n(4'b1101, BC, "R2");
    lvl = 1; run = 0;
    foreach (bits[i]) begin
      if (!bits[i]) lvl = ~lvl;
      push_n({2'b11, ~lvl, lvl}, BC, body_tag);
      run = bits[i] ? run + 1 : 0;
      if (run == 6) begin
        lvl = ~lvl; run = 0;                                       // stuffed 0 (R5)
        push_n({2'b11, ~lvl, lvl}, BC, "R5");
      end
    end
    push_n(4'b1100, 2*BC, "R7");
    push_n(4'b1101, BC, "R7");
    push_n(4'b0000, 1, "R7");
  endtask

  task automatic send(input bit hs, input bit ack, input int count, input bit valid,
                      input string body_tag, input int poke_at);
    int n;
    build(hs, ack, count, valid, body_tag);
    takes = 0; src_idx = 0; took_prev = 0;
    hs_mode = hs; hs_ack = ack; byte_count = 8'(count); data_valid = valid;
    start = 1;
    n = exp_q.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 0;
      check({busy, usb_oe, usb_dp, usb_dm} == exp_q[i], tag_q[i],
            {busy, usb_oe, usb_dp, usb_dm}, exp_q[i]);
      if (i == poke_at) begin
        start = 1; hs_mode = 1; byte_count = 8'd7;               // R9: ignored
      end
    end
    check(takes == (hs ? 0 : (count <= 1 ? 0 : count - 1)), hs ? "R8" : "R6", takes,
          hs ? 0 : (count <= 1 ? 0 : count - 1));
    repeat (3) @(negedge clk);
    check({busy, usb_oe, usb_dp, usb_dm} == 4'b0000, "R1", {busy, usb_oe, usb_dp, usb_dm}, 0);
  endtask

  task automatic write_addr(input logic [6:0] a);
    addr_in = a; addr_wr = 1;
    @(negedge clk);
    addr_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 0; start = 0; hs_mode = 0; hs_ack = 0; byte_count = 0;
    data_valid = 1; addr_wr = 0; addr_in = 0;
    for (int i = 0; i < 8; i++) src[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check({busy, usb_oe, usb_dp, usb_dm} == 4'b0000, "R1", {busy, usb_oe, usb_dp, usb_dm}, 0);
    check(dev_addr == 7'd0, "R1", dev_addr, 0);

    write_addr(7'h2A);
    send(1, 1, 0, 1, "R8", -1);                                    // ACK
    check(dev_addr == 7'd0, "R10", dev_addr, 0);
    send(1, 0, 5, 1, "R8", -1);                                    // NAK, count ignored
    check(dev_addr == 7'd0, "R10", dev_addr, 0);

    // R5: long run of ones across a byte boundary
    src[0] = 8'hFF; src[1] = 8'hFF;
    send(0, 0, 3, 1, "R5", -1);
    check(dev_addr == 7'h2A, "R10", dev_addr, 7'h2A);

    // R5: sixth 1 is the final bit; R9: start mid packet ignored
    src[0] = 8'hFC;
    send(0, 0, 2, 1, "R5", 40);

    // R6: counts 1 and 0 send sync only
    send(0, 0, 1, 1, "R6", -1);
    send(0, 0, 0, 1, "R6", -1);

    // R6: data_valid low gives a zero byte
    src[0] = 8'hA5;
    send(0, 0, 2, 0, "R6", -1);

    // R3/R4: mixed payload, then a new address committed
    write_addr(7'h11);
    src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'h7E;
    send(0, 0, 4, 1, "R4", -1);
    check(dev_addr == 7'h11, "R10", dev_addr, 7'h11);

    finish_up();
  end
endmodule